// File: doc/BRIEF.md
# S/PDIF Consumer-Mode Transmitter

This block turns a stream of stereo PCM pairs into one biphase-mark coded serial line of the kind used by consumer digital audio links. Each frame carries a left and then a right subframe of 32 time slots, and 192 frames make one channel-status block. The block runs on a clock at 128 times the sample rate, so one clock cycle is one half-cell of the line code and one frame lasts 128 cycles.

Samples arrive on a valid/ready interface. A single holding register sits in front of the frame register. `s_ready` is high whenever that holding register is empty. A pair accepted while the holding register is empty waits there until the next frame start, when it moves into the frame register. If no pair is available at a frame start, that frame carries silence. If the holding register is empty and a pair is offered in the frame-start cycle itself, the pair bypasses the holding register and is sent in that frame. The producer may hold `s_valid` high for as long as it likes, and nothing is taken while `s_ready` is low. Validity, channel-status bits and the transmit enable are plain level controls.

Samples narrower than 24 bits are placed at the top of the audio field with zeros below. The user-data bit is always zero. Channel-status bits 0 to 29 come from an input vector, and every later bit of the 192-bit word is zero.

Top module: `spdif_tx`

## Requirements
- R1: A frame is a left subframe followed by a right subframe of 64 half-cells each. The frame number counts 0 to 191 and then wraps to 0, and the block-start preamble appears again on the left subframe after the wrap.
- R2: In slots 4 to 31 the line changes level at the start of every slot, and changes again in the middle of the slot exactly when that slot's bit is 1.
- R3: Slots 0 to 3 carry a preamble of 8 half-cells. Written first to last, and taken relative to a line that was low before the preamble, the patterns are 11101000 for the left subframe of frame 0, 11100010 for every other left subframe and 11100100 for every right subframe. If the line was high before the preamble, the pattern is inverted.
- R4: Slots 4 to 27 carry the 24-bit audio field LSB first (slot 4 = field bit 0, slot 27 = field bit 23). A sample of SAMPLE_W bits fills field bits 23 down to 24-SAMPLE_W, and the bits below are zero.
- R5: Slot 28 equals `valid_flag`, and slot 29 (the user bit) is always 0.
- R6: Slot 30 of both subframes of frame n carries channel-status bit n. That bit is `cs_bits[n]` for n < 30 and 0 for n >= 30.
- R7: Slot 31 makes the count of ones over slots 4 to 31 even.
- R8: While `tx_en` is low, `spdif_out` is 0. The half-cell in which `tx_en` is first seen high is half-cell 0 of frame 0 of a new block.
- R9: `s_ready` is 1 exactly when the holding register is empty, and it is 1 after reset. A held pair is used at the next frame start. A frame that starts with no pair held and none offered carries all-zero audio in both subframes.
- R10: If the holding register is empty and `s_valid` is high in a frame-start cycle, that pair is taken and sent in the frame that starts there, and `s_ready` stays 1.
- R11: While `s_ready` is low, the values on `s_left` and `s_right` are ignored, and the pair already held is the one that gets sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cell clock, 128 times the sample rate |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable; the line is held low while it is low |
| valid_flag | input | 1 | Value sent in the validity slot |
| cs_bits | input | 30 | Programmable channel-status bits 0 to 29 |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty; pair accepted when both are high |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| spdif_out | output | 1 | Biphase-mark coded serial line |

## Verification
A sample handshake and the frame-start load can happen on the same clock edge. The bench sets this up by draining the holding register with the producer stopped. It then raises `s_valid` exactly for the edge at which the half-cell counter returns to zero. The frame decoded from the line must contain that pair, and `s_ready` must read high right after the edge. The same decoding also checks the opposite case: with the producer holding `s_valid` high and changing its data every cycle while `s_ready` is low, only the data present at the accepting edge may appear on the line.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  // Line framing constants
  localparam int SLOTS_PER_SUB   = 32;
  localparam int HALVES_PER_SUB  = 2 * SLOTS_PER_SUB;
  localparam int HALVES_PER_FRM  = 2 * HALVES_PER_SUB;
  localparam int CYC_W           = $clog2(HALVES_PER_FRM);
  localparam int SLOT_W          = $clog2(SLOTS_PER_SUB);
  localparam int AUDIO_W         = 24;
  localparam int CS_PROG         = 30;
  localparam int PRE_HALVES      = 8;

  // Preamble shapes, first half-cell in the MSB, for a line that was low before
  localparam logic [PRE_HALVES-1:0] PAT_BLOCK = 8'b1110_1000;
  localparam logic [PRE_HALVES-1:0] PAT_LEFT  = 8'b1110_0010;
  localparam logic [PRE_HALVES-1:0] PAT_RIGHT = 8'b1110_0100;

  typedef enum logic [1:0] {
    PRE_BLK = 2'd0,
    PRE_LFT = 2'd1,
    PRE_RGT = 2'd2
  } pre_kind_e;

  typedef logic [SLOTS_PER_SUB-1:0] sub_word_t;

endpackage

// File: rtl/spdif_frame_timer.sv
module spdif_frame_timer
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_LEN = 192,
  localparam int FRAME_W = $clog2(BLOCK_LEN)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  output logic               half,
  output logic [SLOT_W-1:0]  slot,
  output logic               sub,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_start
);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      frame <= '0;
    end else if (!run) begin
      cyc   <= '0;
      frame <= '0;
    end else begin
      cyc <= cyc + 1'b1;
      if (cyc == CYC_W'(HALVES_PER_FRM - 1)) begin
        if (frame == FRAME_W'(BLOCK_LEN - 1)) frame <= '0;
        else                                  frame <= frame + 1'b1;
      end
    end
  end

  assign half        = cyc[0];
  assign slot        = cyc[SLOT_W:1];
  assign sub         = cyc[CYC_W-1];
  assign frame_start = run && (cyc == '0);

  // R1: the frame number never leaves the block
  assert_frame_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame < FRAME_W'(BLOCK_LEN));

  // R1: after the last half-cell of the last frame the block restarts
  assert_block_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == CYC_W'(HALVES_PER_FRM - 1) && frame == FRAME_W'(BLOCK_LEN - 1))
    |=> (!run || (frame == '0 && cyc == '0)));

  // R8: enabling always begins at half-cell 0 of frame 0
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cyc == '0 && frame == '0));

endmodule

// File: rtl/spdif_pcm_buffer.sv
module spdif_pcm_buffer
  import spdif_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  localparam int PAD_W = AUDIO_W - SAMPLE_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic [AUDIO_W-1:0]  cur_left,
  output logic [AUDIO_W-1:0]  cur_right
);

  logic                hold_full;
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SAMPLE_W-1:0] frm_l, frm_r;
  logic                take;

  assign s_ready = !hold_full;
  assign take    = s_valid && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      frm_l     <= '0;
      frm_r     <= '0;
    end else if (load) begin
      if (hold_full) begin
        frm_l     <= hold_l;
        frm_r     <= hold_r;
        hold_full <= 1'b0;
      end else if (take) begin
        frm_l <= s_left;
        frm_r <= s_right;
      end else begin
        frm_l <= '0;
        frm_r <= '0;
      end
    end else if (take) begin
      hold_l    <= s_left;
      hold_r    <= s_right;
      hold_full <= 1'b1;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cur_left  = {frm_l, {PAD_W{1'b0}}};
      assign cur_right = {frm_r, {PAD_W{1'b0}}};
    end else begin : g_full
      assign cur_left  = frm_l;
      assign cur_right = frm_r;
    end
  endgenerate

  // R11: a held pair stays untouched until a frame start takes it
  assert_hold_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> (hold_full && $stable(hold_l) && $stable(hold_r)));

  // R10: a pair offered in the frame-start cycle to an empty buffer bypasses it
  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold_full && s_valid) |=> (s_ready && frm_l == $past(s_left)
                                         && frm_r == $past(s_right)));

endmodule

// File: rtl/spdif_subframe_fmt.sv
module spdif_subframe_fmt
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_LEN = 192,
  localparam int FRAME_W = $clog2(BLOCK_LEN)
)(
  input  logic               sub,
  input  logic [FRAME_W-1:0] frame,
  input  logic [AUDIO_W-1:0] cur_left,
  input  logic [AUDIO_W-1:0] cur_right,
  input  logic               valid_flag,
  input  logic [CS_PROG-1:0] cs_bits,
  output sub_word_t          word,
  output pre_kind_e          kind
);

  logic cs_bit;

  always_comb begin
    cs_bit = 1'b0;
    for (int i = 0; i < CS_PROG; i++) begin
      if (frame == FRAME_W'(i)) cs_bit = cs_bits[i];
    end
  end

  always_comb begin
    word        = '0;
    word[27:4]  = sub ? cur_right : cur_left;
    word[28]    = valid_flag;
    word[29]    = 1'b0;
    word[30]    = cs_bit;
    word[31]    = ^word[30:4];
  end

  always_comb begin
    if (sub)                kind = PRE_RGT;
    else if (frame == '0)   kind = PRE_BLK;
    else                    kind = PRE_LFT;
  end

endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
  import spdif_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              half,
  input  logic [SLOT_W-1:0] slot,
  input  pre_kind_e         kind,
  input  sub_word_t         word,
  output logic              line
);

  logic                  line_q, pol_q, pol_now, nxt, in_pre;
  logic [2:0]            pidx;
  logic [PRE_HALVES-1:0] pat;

  assign in_pre = (slot[SLOT_W-1:2] == '0);
  assign pidx   = {slot[1:0], half};

  always_comb begin
    case (kind)
      PRE_BLK: pat = PAT_BLOCK;
      PRE_LFT: pat = PAT_LEFT;
      default: pat = PAT_RIGHT;
    endcase
  end

  always_comb begin
    pol_now = (pidx == 3'd0) ? line_q : pol_q;
    if (in_pre)     nxt = pat[3'd7 - pidx] ^ pol_now;
    else if (!half) nxt = ~line_q;
    else            nxt = word[slot] ? ~line_q : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (!run) begin
      line_q <= 1'b0;
    end else begin
      line_q <= nxt;
      if (in_pre && pidx == 3'd0) pol_q <= line_q;
    end
  end

  assign line = line_q;

  // R8: a disabled transmitter keeps the line low
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !line_q);

  // R2: every data slot opens with a level change
  assert_cell_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !in_pre && !half) |=> (line_q != $past(line_q)));

  // R3: every preamble opens with a level change
  assert_preamble_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && in_pre && pidx == 3'd0) |=> (line_q != $past(line_q)));

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int BLOCK_LEN = 192
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                valid_flag,
  input  logic [CS_PROG-1:0]  cs_bits,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                spdif_out
);

  localparam int FRAME_W = $clog2(BLOCK_LEN);

  logic               half, sub, frame_start;
  logic [SLOT_W-1:0]  slot;
  logic [FRAME_W-1:0] frame;
  logic [AUDIO_W-1:0] cur_left, cur_right;
  sub_word_t          word;
  pre_kind_e          kind;

  spdif_frame_timer #(.BLOCK_LEN(BLOCK_LEN)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (tx_en),
    .half        (half),
    .slot        (slot),
    .sub         (sub),
    .frame       (frame),
    .frame_start (frame_start)
  );

  spdif_pcm_buffer #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_start),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_left    (s_left),
    .s_right   (s_right),
    .cur_left  (cur_left),
    .cur_right (cur_right)
  );

  spdif_subframe_fmt #(.BLOCK_LEN(BLOCK_LEN)) u_fmt (
    .sub        (sub),
    .frame      (frame),
    .cur_left   (cur_left),
    .cur_right  (cur_right),
    .valid_flag (valid_flag),
    .cs_bits    (cs_bits),
    .word       (word),
    .kind       (kind)
  );

  spdif_bmc_enc u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tx_en),
    .half  (half),
    .slot  (slot),
    .kind  (kind),
    .word  (word),
    .line  (spdif_out)
  );

endmodule

// File: tb/sim_spdif_tx.sv
module sim_spdif_tx;

  localparam int SW = 20;
  localparam int BL = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic          valid_flag = 1'b0;
  logic [29:0]   cs_bits = '0;
  logic          s_valid = 1'b0;
  logic [SW-1:0] s_left = '0;
  logic [SW-1:0] s_right = '0;
  wire           s_ready;
  wire           spdif_out;

  always #10 clk = ~clk;

  spdif_tx #(.SAMPLE_W(SW), .BLOCK_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .valid_flag(valid_flag),
    .cs_bits(cs_bits), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .spdif_out(spdif_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expectation queue of accepted pairs with the edge they were taken on
  logic [2*SW-1:0] q_data[$];
  longint          q_edge[$];
  longint          gedge = 0;
  int              en_idx = 0;
  int              prod_mode = 0;   // 0 off, 1 sparse random, 2 always pushing
  bit              prev_lvl = 0;
  bit              hc[64];
  int              cur_frame = 0;
  logic [SW-1:0]   exp_l = '0, exp_r = '0;
  logic [SW-1:0]   dec_l = '0, dec_r = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pre_pat(input bit right, input int f, input bit p);
    logic [7:0] r;
    r = right ? 8'b1110_0100 : ((f == 0) ? 8'b1110_1000 : 8'b1110_0010);
    return p ? ~r : r;
  endfunction

  function automatic logic [23:0] field_of(input logic [SW-1:0] s);
    return {s, {(24-SW){1'b0}}};
  endfunction

  task automatic check_sub(input bit right, input int f, input int h);
    logic [7:0]  got;
    logic [31:0] b;
    bit          code_ok;
    logic [SW-1:0] es;
    got = '0; b = '0; code_ok = 1;
    for (int k = 0; k < 8; k++) got[7-k] = hc[k];
    chk(got == pre_pat(right, f, prev_lvl), "R3", "preamble", 32'(got), 32'(pre_pat(right, f, prev_lvl)));
    if (!right && f == 0 && h >= 128*BL)
      chk(got == pre_pat(0, 0, prev_lvl), "R1", "block preamble after wrap", 32'(got), 32'(pre_pat(0, 0, prev_lvl)));
    if (!right && h < 128)
      chk(got == pre_pat(0, 0, prev_lvl), "R8", "first frame after enable", 32'(got), 32'(pre_pat(0, 0, prev_lvl)));
    for (int k = 4; k < 32; k++) begin
      if (hc[2*k] == hc[2*k-1]) code_ok = 0;
      b[k] = hc[2*k] ^ hc[2*k+1];
    end
    chk(code_ok, "R2", "cell boundary transition", 32'(code_ok), 32'd1);
    es = right ? exp_r : exp_l;
    chk(b[27:4] == field_of(es), "R4", "audio field", 32'(b[27:4]), 32'(field_of(es)));
    chk(b[28] == valid_flag && b[29] == 1'b0, "R5", "validity/user", 32'(b[29:28]), 32'({1'b0, valid_flag}));
    chk(b[30] == ((f < 30) ? cs_bits[f] : 1'b0), "R6", "channel status", 32'(b[30]),
        32'((f < 30) ? cs_bits[f] : 1'b0));
    chk((^b[31:4]) == 1'b0, "R7", "even parity", b, 32'd0);
    if (right) dec_r = b[27:28-SW]; else dec_l = b[27:28-SW];
    prev_lvl = hc[63];
  endtask

  task automatic observe(input bit en);
    int h, pos;
    if (!en) begin
      en_idx = 0;
      prev_lvl = 0;
      chk(spdif_out == 1'b0, "R8", "idle line", 32'(spdif_out), 32'd0);
      return;
    end
    h = en_idx;
    en_idx++;
    pos = h % 128;
    if (pos == 0) begin
      cur_frame = (h / 128) % BL;
      if (q_data.size() > 0 && q_edge[0] <= gedge) begin
        {exp_l, exp_r} = q_data.pop_front();
        void'(q_edge.pop_front());
      end else begin
        exp_l = '0; exp_r = '0;
      end
    end
    hc[pos % 64] = spdif_out;
    if (pos % 64 == 63) check_sub(pos >= 64, cur_frame, h);
  endtask

  task automatic step();
    bit hs, en;
    if (prod_mode == 1 && !s_valid && ($urandom % 8 == 0)) begin
      s_valid = 1; s_left = SW'($urandom); s_right = SW'($urandom);
    end else if (prod_mode == 2) begin
      s_valid = 1; s_left = SW'($urandom); s_right = SW'($urandom);
    end
    hs = s_valid && s_ready;
    en = tx_en;
    @(posedge clk);
    gedge++;
    @(negedge clk);
    if (hs) begin
      q_data.push_back({s_left, s_right});
      q_edge.push_back(gedge);
      s_valid = 0;
    end
    observe(en);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
    end
  end

  initial begin
    logic [SW-1:0] cl, cr;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(spdif_out == 1'b0, "R8", "reset line", 32'(spdif_out), 32'd0);
    chk(s_ready == 1'b1, "R9", "ready after reset", 32'(s_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    cs_bits = 30'($urandom);
    valid_flag = 0;

    // one pair accepted while idle fills the holding register
    s_valid = 1; s_left = SW'($urandom); s_right = SW'($urandom);
    step();
    chk(s_ready == 1'b0, "R9", "ready low while holding", 32'(s_ready), 32'd0);
    // pushing new data each cycle while full must be ignored (R11)
    prod_mode = 2;
    repeat (12) step();
    chk(s_ready == 1'b0, "R11", "still holding", 32'(s_ready), 32'd0);

    // long run across the block wrap; first frames pushy, rest sparse random
    tx_en = 1;
    repeat (20*128) step();
    prod_mode = 1;
    repeat (185*128) step();

    // underrun: producer stops, buffer drains, silence follows (R9)
    prod_mode = 0;
    repeat (4*128) step();
    chk(dec_l == '0 && dec_r == '0, "R9", "underrun silence", 32'({dec_l[7:0], dec_r[7:0]}), 32'd0);
    chk(s_ready == 1'b1, "R9", "ready when drained", 32'(s_ready), 32'd1);

    // collision: offer exactly on a frame-start edge with an empty buffer (R10)
    while (en_idx % 128 != 0) step();
    cl = SW'($urandom); cr = SW'($urandom);
    s_valid = 1; s_left = cl; s_right = cr;
    step();
    chk(s_ready == 1'b1, "R10", "ready after bypass", 32'(s_ready), 32'd1);
    repeat (127) step();
    chk(dec_l == cl, "R10", "bypass left", 32'(dec_l), 32'(cl));
    chk(dec_r == cr, "R10", "bypass right", 32'(dec_r), 32'(cr));

    // disable mid-frame, change controls, restart at a new block (R8)
    repeat (37) step();
    tx_en = 0;
    repeat (9) step();
    valid_flag = 1;
    cs_bits = 30'($urandom);
    prod_mode = 1;
    tx_en = 1;
    repeat (40*128) step();

    done = 1;
    report();
  end

endmodule